// File: doc/BRIEF.md
# Key Matrix Scanner with Any-Key Wake

This block scans a key matrix of 16 column lines and 8 row lines. Column lines are driven active-low. Row lines are pulled up and read active-low. During a scan a single low column travels from column 0 up to column 15. After each column is driven, the block waits a settle interval. It then captures the rows and turns every pressed key into an 8-bit scan code. Each code goes into a 16-entry first-in first-out queue. A consumer reads the head of the queue and removes it with a one-cycle pop strobe.

Between scans the block can be parked. While parked, all columns are driven low, so a press of any key pulls at least one row low and raises a wake request. The wake request is serviced by starting a scan. The scan first releases every column to high for one cycle and then walks the low column as usual. Debouncing beyond the settle wait and translation of codes to characters belong to the consumer.

Top module: `kbd_matrix_scanner`

## Requirements
- R1: After reset, every column output is high and `code_valid`, `overflow`, `wake` and `busy` are low.
- R2: A scan accepted from idle or parked first holds all columns high for one cycle. It then drives pattern 0xFFFE, which pulls only column 0 (bit 0) low. Each following pattern is the previous one shifted left with a 1 filled into bit 0, so exactly one column is low at a time, in ascending order. The scan ends when the next pattern would be 0xFFFF, and all columns then return high.
- R3: Each column pattern is held for `settle_len`+1 cycles before the rows are captured. A scan with no key pressed keeps `busy` high for exactly 1+16*(`settle_len`+3) cycles.
- R4: A row read low while column c is driven means key (r, c) is pressed. Its code carries the row index r in bits 7:4 and the column index c in bits 3:0.
- R5: Codes are produced column by column in ascending column order. Within one column they are produced in ascending row order.
- R6: `code_valid` is high whenever the queue holds a code, and `code_out` shows the oldest code. A `code_pop` while valid removes that code. The queue holds up to 16 codes.
- R7: A code produced while the queue holds 16 codes is discarded and sets `overflow`. `overflow` then stays high until reset, and it is never set while the queue has room.
- R8: `park_req` while idle drives all 16 columns low. While parked, `wake` is high exactly when at least one row input is low.
- R9: `scan_start` while parked leaves the parked state and drops `wake`, then follows R2. When `scan_start` and `park_req` are both high in the same idle cycle, the scan wins.
- R10: `scan_start` and `park_req` have no effect while a scan is in progress. The scan's timing and column order are unchanged, and the block ends in idle with all columns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| scan_start | input | 1 | Request one full matrix scan |
| park_req | input | 1 | Request the all-columns-low parked state |
| settle_len | input | 8 | Extra settle cycles per column before rows are captured |
| col_n | output | 16 | Column drive, active low |
| row_n | input | 8 | Row sense, active low with external pull-ups |
| wake | output | 1 | Any key pressed while parked |
| busy | output | 1 | A scan is in progress |
| code_out | output | 8 | Oldest queued scan code: row in bits 7:4, column in bits 3:0 |
| code_valid | output | 1 | Queue is not empty |
| code_pop | input | 1 | Remove the code shown on `code_out` |
| overflow | output | 1 | Sticky: a code was dropped on a full queue |

## Verification
The scan is exercised with no keys, with a single key in the middle of the matrix, with several rows pressed in one column together with keys in the first and last columns, and with a diagonal pattern at zero settle. Together these separate errors in column order, row order, nibble placement and the settle count. A block of twenty keys with the consumer stalled shows whether the sixteenth code is the last one kept and whether the dropped-code flag stays set after the queue drains. Parking is tried with the matrix empty, with one key pressed and released, and with scan and park requested in the same cycle. Scan and park requests pulsed in the middle of a scan show whether the scan ignores them.

// File: rtl/kbd_scan_pkg.sv
package kbd_scan_pkg;

  localparam int unsigned KS_COLS   = 16;
  localparam int unsigned KS_ROWS   = 8;
  localparam int unsigned KS_QDEPTH = 16;
  localparam int unsigned KS_NIB    = 4;
  localparam int unsigned KS_CODE_W = 2 * KS_NIB;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PARK,
    ST_LIFT,
    ST_SETTLE,
    ST_SAMPLE,
    ST_EMIT
  } ks_state_e;

  // Row index in the upper nibble, column index in the lower nibble.
  function automatic logic [KS_CODE_W-1:0] pack_code(input logic [KS_NIB-1:0] row_idx,
                                                     input logic [KS_NIB-1:0] col_idx);
    return {row_idx, col_idx};
  endfunction

endpackage

// File: rtl/kbd_col_sequencer.sv
module kbd_col_sequencer
  import kbd_scan_pkg::*;
#(
  parameter int unsigned COLS = KS_COLS
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     load,
  input  logic                     advance,
  output logic [COLS-1:0]          pattern,
  output logic [$clog2(COLS)-1:0]  col_idx,
  output logic                     last
);

  localparam int unsigned IDX_W = $clog2(COLS);

  // Move the low bit up one column, refilling column 0 with an inactive 1.
  function automatic logic [COLS-1:0] walk_zero(input logic [COLS-1:0] p);
    return {p[COLS-2:0], 1'b1};
  endfunction

  function automatic logic [COLS-1:0] first_pattern();
    return {{(COLS-1){1'b1}}, 1'b0};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pattern <= '1;
      col_idx <= '0;
    end else if (load) begin
      pattern <= first_pattern();
      col_idx <= '0;
    end else if (advance) begin
      pattern <= walk_zero(pattern);
      col_idx <= col_idx + IDX_W'(1);
    end
  end

  assign last = (walk_zero(pattern) == '1);

endmodule

// File: rtl/kbd_row_picker.sv
module kbd_row_picker
  import kbd_scan_pkg::*;
#(
  parameter int unsigned ROWS = KS_ROWS
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     capture,
  input  logic [ROWS-1:0]          row_n,
  input  logic                     take,
  output logic                     any,
  output logic [$clog2(ROWS)-1:0]  row_idx
);

  localparam int unsigned IDX_W = $clog2(ROWS);

  logic [ROWS-1:0] pressed;

  // Lowest pressed row wins, giving ascending row order.
  function automatic logic [IDX_W-1:0] lowest_set(input logic [ROWS-1:0] m);
    logic [IDX_W-1:0] idx;
    idx = '0;
    for (int i = ROWS - 1; i >= 0; i--) begin
      if (m[i]) idx = IDX_W'(i);
    end
    return idx;
  endfunction

  function automatic logic [ROWS-1:0] drop_row(input logic [ROWS-1:0] m,
                                               input logic [IDX_W-1:0] idx);
    logic [ROWS-1:0] r;
    r = m;
    r[idx] = 1'b0;
    return r;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pressed <= '0;
    end else if (capture) begin
      pressed <= ~row_n;
    end else if (take) begin
      pressed <= drop_row(pressed, row_idx);
    end
  end

  assign any     = |pressed;
  assign row_idx = lowest_set(pressed);

endmodule

// File: rtl/kbd_code_fifo.sv
module kbd_code_fifo
  import kbd_scan_pkg::*;
#(
  parameter int unsigned DEPTH = KS_QDEPTH,
  parameter int unsigned W     = KS_CODE_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         valid,
  output logic         full
);

  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr;
  logic [AW-1:0] rd_ptr;
  logic [CW-1:0] count;
  logic          do_push;
  logic          do_pop;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign full    = (count == CW'(DEPTH));
  assign valid   = (count != '0);
  assign do_push = push && !full;
  assign do_pop  = pop && valid;
  assign head    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= bump(wr_ptr);
      if (do_pop)  rd_ptr <= bump(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

endmodule

// File: rtl/kbd_matrix_scanner.sv
module kbd_matrix_scanner
  import kbd_scan_pkg::*;
#(
  parameter int unsigned COLS     = KS_COLS,
  parameter int unsigned ROWS     = KS_ROWS,
  parameter int unsigned QDEPTH   = KS_QDEPTH,
  parameter int unsigned SETTLE_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 scan_start,
  input  logic                 park_req,
  input  logic [SETTLE_W-1:0]  settle_len,
  output logic [COLS-1:0]      col_n,
  input  logic [ROWS-1:0]      row_n,
  output logic                 wake,
  output logic                 busy,
  output logic [KS_CODE_W-1:0] code_out,
  output logic                 code_valid,
  input  logic                 code_pop,
  output logic                 overflow
);

  localparam int unsigned CIDX_W = $clog2(COLS);
  localparam int unsigned RIDX_W = $clog2(ROWS);

  ks_state_e             state;
  logic [SETTLE_W-1:0]   settle_cnt;
  logic [COLS-1:0]       pattern;
  logic [CIDX_W-1:0]     col_idx;
  logic                  col_last;
  logic                  row_any;
  logic [RIDX_W-1:0]     row_idx;
  logic                  q_full;

  // Named internal events, also observed by the checker.
  logic                  seq_load;
  logic                  seq_advance;
  logic                  row_capture;
  logic                  push_fire;
  logic                  drop_fire;
  logic                  settle_done;
  logic [KS_CODE_W-1:0]  new_code;

  assign seq_load    = (state == ST_LIFT);
  assign settle_done = (state == ST_SETTLE) && (settle_cnt == settle_len);
  assign row_capture = (state == ST_SAMPLE);
  assign push_fire   = (state == ST_EMIT) && row_any;
  assign seq_advance = (state == ST_EMIT) && !row_any && !col_last;
  assign drop_fire   = push_fire && q_full;
  assign new_code    = pack_code(KS_NIB'(row_idx), KS_NIB'(col_idx));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      settle_cnt <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (scan_start)    state <= ST_LIFT;
          else if (park_req) state <= ST_PARK;
        end
        ST_PARK: begin
          if (scan_start) state <= ST_LIFT;
        end
        ST_LIFT: begin
          settle_cnt <= '0;
          state      <= ST_SETTLE;
        end
        ST_SETTLE: begin
          if (settle_done) state <= ST_SAMPLE;
          else             settle_cnt <= settle_cnt + SETTLE_W'(1);
        end
        ST_SAMPLE: state <= ST_EMIT;
        ST_EMIT: begin
          if (!row_any) begin
            settle_cnt <= '0;
            state      <= col_last ? ST_IDLE : ST_SETTLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         overflow <= 1'b0;
    else if (drop_fire) overflow <= 1'b1;
  end

  always_comb begin
    unique case (state)
      ST_PARK:                       col_n = '0;
      ST_SETTLE, ST_SAMPLE, ST_EMIT: col_n = pattern;
      default:                       col_n = '1;
    endcase
  end

  assign busy = (state == ST_LIFT) || (state == ST_SETTLE) ||
                (state == ST_SAMPLE) || (state == ST_EMIT);
  assign wake = (state == ST_PARK) && !(&row_n);

  kbd_col_sequencer #(.COLS(COLS)) u_cols (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (seq_load),
    .advance (seq_advance),
    .pattern (pattern),
    .col_idx (col_idx),
    .last    (col_last)
  );

  kbd_row_picker #(.ROWS(ROWS)) u_rows (
    .clk     (clk),
    .rst_n   (rst_n),
    .capture (row_capture),
    .row_n   (row_n),
    .take    (push_fire),
    .any     (row_any),
    .row_idx (row_idx)
  );

  kbd_code_fifo #(.DEPTH(QDEPTH), .W(KS_CODE_W)) u_queue (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push_fire),
    .push_data (new_code),
    .pop       (code_pop),
    .head      (code_out),
    .valid     (code_valid),
    .full      (q_full)
  );

endmodule

// File: rtl/kbd_scan_checker.sv
module kbd_scan_checker #(
  parameter int unsigned COLS = 16,
  parameter int unsigned ROWS = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic [COLS-1:0] col_n,
  input logic [ROWS-1:0] row_n,
  input logic            busy,
  input logic            wake,
  input logic            overflow,
  input logic            code_valid,
  input logic            code_pop,
  input logic [7:0]      code_out,
  input logic            push_fire,
  input logic            row_capture
);

  // R2: the first scan cycle releases every column.
  a_r2_lift_all_high: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (col_n == '1));

  // R2: during a scan at most one column is low.
  a_r2_single_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (col_n != '1)) |-> ($countones(~col_n) == 1));

  // R3: rows are captured only after the column drive held still.
  a_r3_capture_settled: assert property (@(posedge clk) disable iff (!rst_n)
    row_capture |-> $stable(col_n));

  // R4: a code is produced only while one column is driven.
  a_r4_push_on_column: assert property (@(posedge clk) disable iff (!rst_n)
    push_fire |-> (busy && $countones(~col_n) == 1));

  // R6: the head holds until it is popped.
  a_r6_head_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (code_valid && !code_pop) |=> (code_valid && $stable(code_out)));

  // R7: the dropped-code flag is sticky.
  a_r7_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

  // R8: wake only while all columns are low and a row is pulled low.
  a_r8_wake_parked: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> ((col_n == '0) && (row_n != '1) && !busy));

endmodule

bind kbd_matrix_scanner kbd_scan_checker #(.COLS(COLS), .ROWS(ROWS)) u_kbd_scan_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .col_n       (col_n),
  .row_n       (row_n),
  .busy        (busy),
  .wake        (wake),
  .overflow    (overflow),
  .code_valid  (code_valid),
  .code_pop    (code_pop),
  .code_out    (code_out),
  .push_fire   (push_fire),
  .row_capture (row_capture)
);

// File: tb/tb_kbd_matrix_scanner.sv
`timescale 1ns/1ps
module tb_kbd_matrix_scanner;

  localparam int COLS = 16;
  localparam int ROWS = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scan_start = 1'b0;
  logic        park_req = 1'b0;
  logic [7:0]  settle_len = 8'd2;
  logic [COLS-1:0] col_n;
  logic [ROWS-1:0] row_n;
  logic        wake, busy, code_valid, overflow;
  logic        code_pop = 1'b0;
  logic [7:0]  code_out;

  logic [COLS-1:0] keys [ROWS];
  logic [7:0]  exp_q [$];
  bit          mon_en = 1'b0;
  int          n_checks = 0;
  int          n_err = 0;

  always #2 clk = ~clk;

  // Matrix model: a row is pulled low when a pressed key sits in a low column.
  always_comb begin
    for (int r = 0; r < ROWS; r++) row_n[r] = ~|(keys[r] & ~col_n);
  end

  kbd_matrix_scanner dut (
    .clk(clk), .rst_n(rst_n), .scan_start(scan_start), .park_req(park_req),
    .settle_len(settle_len), .col_n(col_n), .row_n(row_n), .wake(wake),
    .busy(busy), .code_out(code_out), .code_valid(code_valid),
    .code_pop(code_pop), .overflow(overflow)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
  endtask

  task automatic clear_keys();
    for (int r = 0; r < ROWS; r++) keys[r] = '0;
  endtask

  task automatic press(input int r, input int c);
    keys[r][c] = 1'b1;
  endtask

  // Driver side of the scoreboard: expected order is column-major, rows ascending (R4, R5).
  task automatic expect_scan();
    for (int c = 0; c < COLS; c++)
      for (int r = 0; r < ROWS; r++)
        if (keys[r][c]) exp_q.push_back({4'(r), 4'(c)});
  endtask

  // Monitor side: pop and compare each code as it appears.
  always @(negedge clk) begin
    code_pop <= 1'b0;
    if (mon_en && rst_n && code_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R6 unexpected code", code_out, 0);
      end else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        check(code_out == e, "R5 code value/order", code_out, e);
      end
      code_pop <= 1'b1;
    end
  end

  // Start a scan and follow it; optional requests pulsed mid-scan (R10).
  task automatic run_scan(input bit with_park, input bit poke, output int cycles,
                          output int seq_err, output logic [COLS-1:0] first_col,
                          output logic wake_first);
    logic [COLS-1:0] prev;
    int step;
    @(negedge clk);
    scan_start = 1'b1;
    park_req   = with_park;
    @(negedge clk);
    scan_start = 1'b0;
    park_req   = 1'b0;
    first_col  = col_n;
    wake_first = wake;
    cycles = 0; seq_err = 0; step = 0; prev = '1;
    while (busy && cycles < 5000) begin
      cycles++;
      if (col_n != prev) begin
        if (col_n != ~(16'(1) << step)) seq_err++;
        step++;
        prev = col_n;
      end
      if (poke && cycles == 20) begin scan_start = 1'b1; park_req = 1'b1; end
      else if (poke && cycles == 21) begin scan_start = 1'b0; park_req = 1'b0; end
      @(negedge clk);
    end
    scan_start = 1'b0;
    park_req   = 1'b0;
    if (step != COLS) seq_err++;
  endtask

  task automatic drain_check(input string req);
    repeat (60) @(negedge clk);
    check(exp_q.size() == 0, req, exp_q.size(), 0);
  endtask

  initial begin
    #(4 * 150000);
    n_err++;
    $display("FAIL watchdog: run did not complete, actual timeout expected finish");
    summary();
    $finish;
  end

  initial begin
    int cyc, serr;
    logic [COLS-1:0] fc;
    logic wf;
    clear_keys();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(col_n == '1, "R1 columns high", col_n, 16'hFFFF);
    check(!code_valid && !overflow, "R1 queue empty, no overflow", {code_valid, overflow}, 0);
    check(!wake && !busy, "R1 not waking, not busy", {wake, busy}, 0);

    mon_en = 1'b1;

    // R2/R3: empty matrix, settle 2
    settle_len = 8'd2;
    run_scan(1'b0, 1'b0, cyc, serr, fc, wf);
    check(fc == '1, "R2 lift cycle all high", fc, 16'hFFFF);
    check(serr == 0, "R2 walking zero order", serr, 0);
    check(cyc == 1 + 16 * (2 + 3), "R3 scan length settle=2", cyc, 81);
    check(col_n == '1 && !code_valid, "R2 columns released, no codes", col_n, 16'hFFFF);

    // R3 with settle 5
    settle_len = 8'd5;
    run_scan(1'b0, 1'b0, cyc, serr, fc, wf);
    check(cyc == 1 + 16 * (5 + 3), "R3 scan length settle=5", cyc, 129);

    // R4: single key row 3 column 5 -> 0x35
    settle_len = 8'd1;
    clear_keys(); press(3, 5);
    expect_scan();
    check(exp_q[0] == 8'h35, "R4 bench encoding row 3 col 5", exp_q[0], 8'h35);
    run_scan(1'b0, 1'b0, cyc, serr, fc, wf);
    drain_check("R4 single key delivered");

    // R5: several rows in one column plus the edge columns
    clear_keys(); press(7, 9); press(0, 9); press(2, 9); press(5, 0); press(1, 15); press(6, 15);
    expect_scan();
    run_scan(1'b0, 1'b0, cyc, serr, fc, wf);
    check(serr == 0, "R2 order with keys held", serr, 0);
    drain_check("R5 multi-row column order");

    // R5 diagonal at zero settle
    settle_len = 8'd0;
    clear_keys();
    for (int i = 0; i < ROWS; i++) begin press(i, i); press(i, 15 - i); end
    expect_scan();
    run_scan(1'b0, 1'b0, cyc, serr, fc, wf);
    drain_check("R5 diagonal pattern");

    // R10: requests during a scan are ignored
    settle_len = 8'd2;
    clear_keys();
    run_scan(1'b0, 1'b1, cyc, serr, fc, wf);
    check(cyc == 81 && serr == 0, "R10 mid-scan requests ignored", cyc, 81);
    @(negedge clk);
    check(col_n == '1 && !busy, "R10 ends idle, not parked", col_n, 16'hFFFF);

    // R8: parked state and wake
    @(negedge clk); park_req = 1'b1;
    @(negedge clk); park_req = 1'b0;
    check(col_n == '0, "R8 all columns low when parked", col_n, 0);
    check(!wake, "R8 no wake with no key", wake, 0);
    press(4, 11); #1;
    check(wake, "R8 wake on key press", wake, 1);
    clear_keys(); #1;
    check(!wake, "R8 wake drops on release", wake, 0);

    // R9: servicing the wake with a scan
    press(6, 2); #1;
    check(wake, "R8 wake before service", wake, 1);
    expect_scan();
    run_scan(1'b0, 1'b0, cyc, serr, fc, wf);
    check(fc == '1 && !wf, "R9 lift from park, wake dropped", {fc, wf}, {16'hFFFF, 1'b0});
    check(serr == 0, "R9 scan after park", serr, 0);
    drain_check("R9 code after wake");

    // R9: start beats park in the same idle cycle
    clear_keys();
    run_scan(1'b1, 1'b0, cyc, serr, fc, wf);
    check(fc == '1 && cyc == 81, "R9 start wins over park", cyc, 81);

    // R7: overflow with the consumer stalled
    check(!overflow, "R7 no overflow while room", overflow, 0);
    mon_en = 1'b0;
    clear_keys();
    for (int r = 0; r < 5; r++) for (int c = 0; c < 4; c++) press(r, c);
    expect_scan();
    while (exp_q.size() > 16) void'(exp_q.pop_back());
    run_scan(1'b0, 1'b0, cyc, serr, fc, wf);
    @(negedge clk);
    check(overflow, "R7 overflow after drop", overflow, 1);
    check(code_valid, "R6 queue holds codes", code_valid, 1);
    mon_en = 1'b1;
    drain_check("R6 first 16 codes kept in order");
    check(!code_valid, "R7 dropped codes absent", code_valid, 0);
    check(overflow, "R7 overflow sticky after drain", overflow, 1);

    summary();
    $finish;
  end

endmodule